// File: doc/BRIEF.md
# Serial Memory Bus Suspend and Low-Power Controller

This block sits beside the command engine of a serial-bus memory slave and decides when that engine must stand still. It watches the select, serial clock and pause pins. It raises a freeze indication that stops the engine's bit counting and turns the data output to high impedance. The engine itself decodes opcodes. It passes the sleep opcode in as a one-cycle pulse. This block then follows the request through arming, cancellation, entry into the low-power state and the timed recovery that follows.

All pin inputs are asynchronous. They pass through a parameterised synchroniser chain clocked by the system clock. Every decision is then made in that domain. The system clock must therefore run several times faster than the serial clock. The recovery window is a count of system-clock cycles.

A pause (hold) that ends when the select pin rises reports an abort pulse. The engine can then drop a command that was cut short. If that command had not yet been recognised, the engine leaves its write-enable latch as it was before the pause.

Top module: `spi_suspend_ctrl`

## Requirements
- R1: After reset, freeze_o, sleep_o, wake_o, abort_o and proto_err_o are 0, and so_hiz_o is 1 while the select pin is high.
- R2: With select low (cs_ni=0), a falling edge on hold_ni raises freeze_o and so_hiz_o within 4 system clock cycles. After that edge, changes on sck_i do not release the pause.
- R3: A falling hold_ni while select is high has no effect: freeze_o and abort_o stay 0. Selecting later with hold_ni already low does not start a pause either.
- R4: A pause entered while sck_i was 0 ends only when hold_ni is 1 and sck_i is 0 at the same time. Releasing hold_ni while sck_i is 1 keeps freeze_o at 1.
- R5: A pause entered while sck_i was 1 ends only when hold_ni is 1 and sck_i is 1 at the same time. Releasing hold_ni while sck_i is 0 keeps freeze_o at 1.
- R6: A rise of cs_ni during a pause ends the pause. It produces exactly one cycle of abort_o.
- R7: A sleep_op_i pulse while selected arms a sleep request. The next rise of cs_ni then sets sleep_o, freeze_o and so_hiz_o.
- R8: A rising sck_i between the sleep_op_i pulse and the rise of cs_ni cancels the request, so sleep_o stays 0.
- R9: While sleep_o is 1, activity on sck_i and hold_ni changes nothing: sleep_o stays 1 and no abort_o is produced.
- R10: A fall of cs_ni while sleep_o is 1 clears sleep_o. It holds wake_o (and freeze_o) high for exactly REC_CYC system cycles. Both then drop to 0.
- R11: A further fall of cs_ni while wake_o is 1 sets proto_err_o. proto_err_o stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select pin, active low, asynchronous |
| sck_i | input | 1 | Serial clock pin, asynchronous |
| hold_ni | input | 1 | Pause pin, active low, asynchronous |
| sleep_op_i | input | 1 | One-cycle pulse from the command engine: sleep opcode recognised |
| freeze_o | output | 1 | Engine must stop bit counting (pause, sleep or recovery) |
| so_hiz_o | output | 1 | Serial data output must be high impedance |
| sleep_o | output | 1 | Low-power state active |
| wake_o | output | 1 | Recovery window running, commands not yet accepted |
| abort_o | output | 1 | One-cycle pulse: pause ended by deselect, drop the command |
| proto_err_o | output | 1 | Sticky: select fell again inside the recovery window |

## Verification
A pause tracker that stores the wrong serial clock reference shows up at the ports. freeze_o either stays high after a legal release, or drops on an illegal one. This appears within four cycles of the pause pin rising, so the bench sweeps all four entry/release level pairs. An error in the sleep state machine shows on sleep_o one synchroniser delay after the select edge. A recovery counter that is off by one changes the exact count of wake_o cycles, which the bench measures cycle by cycle. A lost sticky flag appears as proto_err_o falling after the window closes.

// File: rtl/spi_suspend_pkg.sv
package spi_suspend_pkg;
  typedef enum logic [1:0] {
    SLP_IDLE   = 2'd0,
    SLP_ARMED  = 2'd1,
    SLP_ASLEEP = 2'd2,
    SLP_WAKE   = 2'd3
  } slp_state_e;

  localparam int unsigned PIN_CS   = 0;
  localparam int unsigned PIN_SCK  = 1;
  localparam int unsigned PIN_HOLD = 2;
  localparam int unsigned NUM_PINS = 3;
endpackage

// File: rtl/spi_suspend_sync.sv
module spi_suspend_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] d;
    if (g == 0) begin : g_first
      assign d = async_i;
    end else begin : g_rest
      assign d = stage_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= RESET_VAL;
      else         stage_q[g] <= d;
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_suspend_hold.sv
module spi_suspend_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_s_i,
  input  logic sck_s_i,
  input  logic hold_s_i,
  input  logic block_i,
  output logic held_o,
  output logic abort_o
);
  logic hold_d_q, held_q, ref_q, abort_q;
  logic hold_fall;

  assign hold_fall = hold_d_q & ~hold_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_d_q <= 1'b1;
      held_q   <= 1'b0;
      ref_q    <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      hold_d_q <= hold_s_i;
      abort_q  <= 1'b0;
      if (!held_q) begin
        if (hold_fall && !cs_s_i && !block_i) begin
          held_q <= 1'b1;
          ref_q  <= sck_s_i;   // release must match this level
        end
      end else if (cs_s_i) begin
        held_q  <= 1'b0;
        abort_q <= 1'b1;
      end else if (hold_s_i && (sck_s_i == ref_q)) begin
        held_q <= 1'b0;
      end
    end
  end

  assign held_o  = held_q;
  assign abort_o = abort_q;

  a_r6_deselect_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_q && cs_s_i |=> !held_q && abort_q);

  a_r6_abort_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_q |=> !abort_q);

  a_r2_entry_needs_low_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(held_q) |-> !$past(hold_s_i) && !$past(cs_s_i));

  a_r4_ref_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_q && $past(held_q) |-> $stable(ref_q));

  a_r5_release_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(held_q) |-> $past(cs_s_i) || ($past(hold_s_i) && ($past(sck_s_i) == $past(ref_q))));
endmodule

// File: rtl/spi_suspend_sleep.sv
module spi_suspend_sleep
  import spi_suspend_pkg::*;
#(
  parameter int unsigned REC_CYC = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_s_i,
  input  logic sck_s_i,
  input  logic sleep_op_i,
  output logic asleep_o,
  output logic waking_o,
  output logic proto_err_o
);
  localparam int unsigned CNT_W = $clog2(REC_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REC_CYC - 1);

  slp_state_e  state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic cs_d_q, sck_d_q, err_q, err_d;
  logic cs_rise, cs_fall, sck_rise;

  assign cs_rise  =  cs_s_i & ~cs_d_q;
  assign cs_fall  = ~cs_s_i &  cs_d_q;
  assign sck_rise =  sck_s_i & ~sck_d_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    err_d   = err_q;
    unique case (state_q)
      SLP_IDLE:   if (sleep_op_i && !cs_s_i) state_d = SLP_ARMED;
      SLP_ARMED: begin
        if (sck_rise)     state_d = SLP_IDLE;   // stray clock cancels
        else if (cs_rise) state_d = SLP_ASLEEP;
      end
      SLP_ASLEEP: begin
        if (cs_fall) begin
          state_d = SLP_WAKE;
          cnt_d   = '0;
        end
      end
      SLP_WAKE: begin
        if (cs_fall) err_d = 1'b1;
        if (cnt_q == CNT_LAST) state_d = SLP_IDLE;
        else                   cnt_d   = cnt_q + 1'b1;
      end
      default: state_d = SLP_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SLP_IDLE;
      cnt_q   <= '0;
      err_q   <= 1'b0;
      cs_d_q  <= 1'b1;
      sck_d_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      err_q   <= err_d;
      cs_d_q  <= cs_s_i;
      sck_d_q <= sck_s_i;
    end
  end

  assign asleep_o    = (state_q == SLP_ASLEEP);
  assign waking_o    = (state_q == SLP_WAKE);
  assign proto_err_o = err_q;

  a_r10_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == SLP_WAKE |-> cnt_q < CNT_W'(REC_CYC));

  a_r7_entry_from_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == SLP_ASLEEP && $past(state_q) != SLP_ASLEEP |-> $past(state_q) == SLP_ARMED);

  a_r8_stray_clock_cancels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == SLP_ARMED && sck_rise |=> state_q == SLP_IDLE);

  a_r11_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);

  a_r10_wake_from_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(waking_o) |-> $past(state_q) == SLP_ASLEEP);
endmodule

// File: rtl/spi_suspend_ctrl.sv
module spi_suspend_ctrl
  import spi_suspend_pkg::*;
#(
  parameter int unsigned REC_CYC     = 50000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic hold_ni,
  input  logic sleep_op_i,
  output logic freeze_o,
  output logic so_hiz_o,
  output logic sleep_o,
  output logic wake_o,
  output logic abort_o,
  output logic proto_err_o
);
  localparam logic [NUM_PINS-1:0] PIN_RST = NUM_PINS'((1 << PIN_CS) | (1 << PIN_HOLD));

  logic [NUM_PINS-1:0] pins_a, pins_s;
  logic held, asleep, waking, hold_abort, err;

  assign pins_a[PIN_CS]   = cs_ni;
  assign pins_a[PIN_SCK]  = sck_i;
  assign pins_a[PIN_HOLD] = hold_ni;

  spi_suspend_sync #(
    .WIDTH     (NUM_PINS),
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (PIN_RST)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pins_a),
    .sync_o  (pins_s)
  );

  spi_suspend_hold u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_s_i   (pins_s[PIN_CS]),
    .sck_s_i  (pins_s[PIN_SCK]),
    .hold_s_i (pins_s[PIN_HOLD]),
    .block_i  (asleep | waking),
    .held_o   (held),
    .abort_o  (hold_abort)
  );

  spi_suspend_sleep #(
    .REC_CYC (REC_CYC)
  ) u_sleep (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_s_i      (pins_s[PIN_CS]),
    .sck_s_i     (pins_s[PIN_SCK]),
    .sleep_op_i  (sleep_op_i),
    .asleep_o    (asleep),
    .waking_o    (waking),
    .proto_err_o (err)
  );

  assign freeze_o    = held | asleep | waking;
  assign so_hiz_o    = pins_s[PIN_CS] | freeze_o;
  assign sleep_o     = asleep;
  assign wake_o      = waking;
  assign abort_o     = hold_abort;
  assign proto_err_o = err;

  a_r9_no_hold_in_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asleep |-> !held && !hold_abort);
endmodule

// File: tb/spi_suspend_ctrl_tb_top.sv
`timescale 1ns/1ps
module spi_suspend_ctrl_tb_top;
  localparam int unsigned REC = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1, sleep_op = 1'b0;
  logic freeze, so_hiz, sleep, wake, abort_p, perr;

  int total = 0, bad = 0;
  int abort_cnt = 0, wake_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_suspend_ctrl #(.REC_CYC(REC), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .hold_ni(hold_n),
    .sleep_op_i(sleep_op), .freeze_o(freeze), .so_hiz_o(so_hiz), .sleep_o(sleep),
    .wake_o(wake), .abort_o(abort_p), .proto_err_o(perr)
  );

  always @(negedge clk) begin
    if (abort_p) abort_cnt++;
    if (wake)    wake_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic op_pulse();
    @(negedge clk) sleep_op = 1'b1;
    @(negedge clk) sleep_op = 1'b0;
  endtask

  task automatic enter_sleep();
    cs_n = 1'b0; settle();
    op_pulse(); settle();
    cs_n = 1'b1; settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int a0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1 reset state
    chk("R1 freeze", freeze, 0);
    chk("R1 sleep", sleep, 0);
    chk("R1 wake", wake, 0);
    chk("R1 abort", abort_cnt, 0);
    chk("R1 proto_err", perr, 0);
    chk("R1 so_hiz", so_hiz, 1);

    // R3 hold while deselected, then select with hold already low
    a0 = abort_cnt;
    hold_n = 1'b0; settle();
    chk("R3 freeze deselected", freeze, 0);
    cs_n = 1'b0; settle();
    chk("R3 freeze select with hold low", freeze, 0);
    chk("R3 so_hiz selected", so_hiz, 0);
    hold_n = 1'b1; settle();
    cs_n = 1'b1; settle();
    chk("R3 abort count", abort_cnt - a0, 0);

    // R2/R4/R5 sweep of entry level e and release level r
    for (int e = 0; e < 2; e++) begin
      for (int r = 0; r < 2; r++) begin
        string rq;
        rq = (e == 0) ? "R4" : "R5";
        cs_n = 1'b0; sck = e[0]; settle();
        hold_n = 1'b0; settle();
        chk($sformatf("R2 freeze e=%0d", e), freeze, 1);
        chk($sformatf("R2 so_hiz e=%0d", e), so_hiz, 1);
        sck = r[0]; settle();
        hold_n = 1'b1; settle();
        chk($sformatf("%s freeze e=%0d r=%0d", rq, e, r), freeze, (r != e) ? 1 : 0);
        sck = e[0]; settle();
        chk($sformatf("%s released e=%0d", rq, e), freeze, 0);
        cs_n = 1'b1; settle();
      end
    end
    sck = 1'b0; settle();

    // R6 deselect during pause
    a0 = abort_cnt;
    cs_n = 1'b0; settle();
    hold_n = 1'b0; settle();
    cs_n = 1'b1; settle();
    chk("R6 abort pulses", abort_cnt - a0, 1);
    chk("R6 freeze cleared", freeze, 0);
    hold_n = 1'b1; settle();

    // R8 stray clock cancels sleep request
    cs_n = 1'b0; settle();
    op_pulse(); settle();
    sck = 1'b1; settle();
    sck = 1'b0; settle();
    cs_n = 1'b1; settle();
    chk("R8 sleep cancelled", sleep, 0);

    // R7 sleep entry
    enter_sleep();
    chk("R7 sleep", sleep, 1);
    chk("R7 freeze", freeze, 1);
    chk("R7 so_hiz", so_hiz, 1);

    // R9 activity ignored while asleep
    a0 = abort_cnt;
    for (int k = 0; k < 3; k++) begin
      sck = 1'b1; settle();
      hold_n = 1'b0; settle();
      sck = 1'b0; settle();
      hold_n = 1'b1; settle();
    end
    chk("R9 still asleep", sleep, 1);
    chk("R9 no abort", abort_cnt - a0, 0);
    chk("R9 wake idle", wake, 0);

    // R10 wake-up window length
    wake_cnt = 0;
    cs_n = 1'b0; settle();
    chk("R10 sleep cleared", sleep, 0);
    chk("R10 waking", wake, 1);
    repeat (REC + 10) @(negedge clk);
    chk("R10 window cycles", wake_cnt, REC);
    chk("R10 freeze released", freeze, 0);
    chk("R10 no error", perr, 0);
    cs_n = 1'b1; settle();

    // R11 select falls again inside window
    enter_sleep();
    cs_n = 1'b0; settle();
    cs_n = 1'b1; settle();
    cs_n = 1'b0; settle();
    chk("R11 error set", perr, 1);
    repeat (REC + 10) @(negedge clk);
    chk("R11 error sticky", perr, 1);
    chk("R11 wake ended", wake, 0);
    cs_n = 1'b1;
    rst_n = 1'b0; settle();
    rst_n = 1'b1; settle();
    chk("R11 cleared by reset", perr, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule